// File: doc/BRIEF.md
# Self-Clearing Two-Domain Soft Reset Controller

This block produces the software resets of a card host controller. Software writes a 32-bit control word that holds three reset request bits: one for the data line, one for the command line and one for the whole controller. A request bit reads back as 1 for as long as its reset is in progress. The block runs one reset round at a time. During a round it drives reset levels into the interconnect-clock logic and into the card-clock logic, and it sends one-cycle clear strobes to the status-flag groups that the round covers. The round ends only when both domains have acknowledged. The request bits of that round then clear by themselves.

The request is carried into the card domain as a toggle through a synchroniser. The card domain holds its local resets for a fixed number of card clocks. It then returns an acknowledge toggle, which is synchronised back into the interconnect domain. The interconnect side also holds its own resets for a minimum number of cycles. The card-detect state and the capability value are kept in a separate holding stage that only the hardware reset reaches, so a reset-all round leaves them untouched.

Top module: `softrst_hub`

## Requirements
- R1: The control word has the data-line request at bit 26, the command-line request at bit 25 and the reset-all request at bit 24. Every other bit reads 0 and ignores writes, so a write that touches only those other bits starts no round.
- R2: Writing 1 to a request bit makes it read 1 on the next cycle. The bit stays 1 until the interconnect side has held its resets for at least IC_HOLD cycles and the card side has acknowledged. It then returns to 0 with no further write.
- R3: Writing 0 to a pending request bit leaves it pending. Writing 1 again to a pending bit starts no extra round, so its group receives exactly one clear strobe.
- R4: During a round, the card-side resets of the round's scope are held high for at least CARD_HOLD card clocks. The request bits stay 1 throughout that time.
- R5: A data-line round raises `clr_dat_grp` for exactly one cycle and asserts `ic_dat_rst` and `cd_dat_rst`. It raises neither `clr_cmd_grp` nor any command or reset-all output.
- R6: A command-line round raises `clr_cmd_grp` for exactly one cycle and asserts `ic_cmd_rst` and `cd_cmd_rst`. It raises neither `clr_dat_grp` nor any data or reset-all output.
- R7: A reset-all round raises both clear strobes and asserts all interconnect and card reset outputs. If a line request is pending when reset-all is requested, the line bit does not clear before the reset-all bit. All of them clear in the same cycle.
- R8: `card_present` follows the synchronised card-detect input. `caps` holds the value of `cap_strap` captured in the first cycle after the hardware reset. Neither changes because of any software reset round, including reset-all.
- R9: `ic_if_rst` is high for the whole of every round, whatever its scope, and low when no round is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect-side clock |
| rst_n | input | 1 | Interconnect-side hardware reset, active low |
| cclk | input | 1 | Card-side clock |
| crst_n | input | 1 | Card-side hardware reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data for the control word |
| rd_data | output | 32 | Control word readback: request bits 26..24, all other bits 0 |
| cap_strap | input | CAP_W | Capability value, captured once after hardware reset |
| card_det_raw | input | 1 | Asynchronous card-detect input |
| ic_if_rst | output | 1 | Interconnect interface reinitialise, high during every round |
| ic_dat_rst | output | 1 | Interconnect data-path reset |
| ic_cmd_rst | output | 1 | Interconnect command-path reset |
| ic_all_rst | output | 1 | Interconnect controller-wide reset |
| cd_dat_rst | output | 1 | Card-domain data-path reset |
| cd_cmd_rst | output | 1 | Card-domain command-path reset |
| cd_all_rst | output | 1 | Card-domain controller-wide reset |
| clr_dat_grp | output | 1 | One-cycle clear strobe for the data-line status group |
| clr_cmd_grp | output | 1 | One-cycle clear strobe for the command-line status group |
| card_present | output | 1 | Synchronised card-detect state |
| caps | output | CAP_W | Captured capability value |

## Verification
The assertions assume that `wr_en` and `wr_data` change only in the interconnect domain. They also assume that `cap_strap` is stable during the first cycle after `rst_n` rises, and that both hardware resets are released before any write. The bench drives every input at the falling edge of its own clock. It sets the strap before it releases reset and changes the strap only afterwards. It issues random request words, including reserved-only patterns, only while the controller is idle. Overlapping requests are exercised only in directed sequences whose outcome is worked out in advance.

// File: rtl/softrst_pkg.sv
// Shared definitions for the soft reset controller.
// Assumes the request field positions below are fixed by the software view.
package softrst_pkg;
    localparam int BIT_ALL = 24;
    localparam int BIT_CMD = 25;
    localparam int BIT_DAT = 26;
    localparam int NREQ    = 3;

    // Scope of a reset round, packed in the same order as bits 26..24.
    typedef struct packed {
        logic dat;
        logic cmd;
        logic all;
    } rst_scope_t;
endpackage

// File: rtl/softrst_sync.sv
// Multi-stage synchroniser for slowly changing or toggle signals.
// Assumes each bit is independent, or that the source holds its value until it has been sampled.
module softrst_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/softrst_req_regs.sv
// Request bits of the control word.
// Writing 1 sets a bit. Writing 0 has no effect. The engine clears bits when a round ends.
// A set and a clear in the same cycle resolve to set, so that the new request is kept.
module softrst_req_regs
    import softrst_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rst_scope_t set_bits,
    input  rst_scope_t clr_bits,
    output rst_scope_t pend
);
    // Update the pending requests.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/softrst_card_side.sv
// Card-domain half of the handshake. It detects a request toggle and holds the
// card resets selected by the scope for HOLD card clocks, then flips the acknowledge toggle.
// Assumes the scope is stable from before the request toggle until the acknowledge.
module softrst_card_side
    import softrst_pkg::*;
#(
    parameter int HOLD   = 4,
    parameter int STAGES = 2
) (
    input  logic       cclk,
    input  logic       crst_n,
    input  logic       req_tgl,
    input  rst_scope_t scope_in,
    output logic       ack_tgl,
    output logic       rst_dat,
    output logic       rst_cmd,
    output logic       rst_all
);
    localparam int CW = $clog2(HOLD + 1);

    logic          req_s, req_d;
    logic [CW-1:0] hold_cnt;
    rst_scope_t    scope_c;

    softrst_sync #(.STAGES(STAGES), .W(1)) u_req_sync (
        .clk(cclk), .rst_n(crst_n), .d(req_tgl), .q(req_s)
    );

    // Detect a request edge, run the hold counter and acknowledge when it expires.
    always_ff @(posedge cclk or negedge crst_n) begin
        if (!crst_n) begin
            req_d    <= 1'b0;
            hold_cnt <= '0;
            scope_c  <= '0;
            ack_tgl  <= 1'b0;
        end else begin
            req_d <= req_s;
            if (req_s != req_d) begin
                hold_cnt <= CW'(HOLD);
                scope_c  <= scope_in;
            end else if (hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
                if (hold_cnt == CW'(1)) ack_tgl <= ~ack_tgl;
            end
        end
    end

    assign rst_dat = (hold_cnt != '0) && (scope_c.dat || scope_c.all);
    assign rst_cmd = (hold_cnt != '0) && (scope_c.cmd || scope_c.all);
    assign rst_all = (hold_cnt != '0) && scope_c.all;
endmodule

// File: rtl/softrst_keep.sv
// State that the software resets must not reach: the synchronised card-detect
// level and the capability value. Only the hardware reset clears this stage.
// Assumes cap_strap is valid in the first cycle after rst_n rises.
module softrst_keep #(
    parameter int CAP_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_det_raw,
    input  logic [CAP_W-1:0] cap_strap,
    output logic             card_present,
    output logic [CAP_W-1:0] caps,
    output logic             caps_vld
);
    softrst_sync #(.STAGES(STAGES), .W(1)) u_det_sync (
        .clk(clk), .rst_n(rst_n), .d(card_det_raw), .q(card_present)
    );

    // Capture the capability strap once after the hardware reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            caps     <= '0;
            caps_vld <= 1'b0;
        end else if (!caps_vld) begin
            caps     <= cap_strap;
            caps_vld <= 1'b1;
        end
    end
endmodule

// File: rtl/softrst_hub.sv
// Top of the soft reset controller. It holds the request bits, runs one
// reset round at a time through an interconnect-side hold and a card-side
// handshake, and drives the reset levels and group clear strobes.
// Assumes the writes come from the clk domain.
module softrst_hub
    import softrst_pkg::*;
#(
    parameter int CARD_HOLD   = 4,
    parameter int IC_HOLD     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CAP_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cclk,
    input  logic             crst_n,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [CAP_W-1:0] cap_strap,
    input  logic             card_det_raw,
    output logic             ic_if_rst,
    output logic             ic_dat_rst,
    output logic             ic_cmd_rst,
    output logic             ic_all_rst,
    output logic             cd_dat_rst,
    output logic             cd_cmd_rst,
    output logic             cd_all_rst,
    output logic             clr_dat_grp,
    output logic             clr_cmd_grp,
    output logic             card_present,
    output logic [CAP_W-1:0] caps
);
    localparam int ICW = $clog2(IC_HOLD + 1);

    typedef enum logic {ST_IDLE, ST_BUSY} eng_st_t;

    eng_st_t        st;
    rst_scope_t     pend, set_bits, clr_bits, scope_q;
    logic           req_tgl, ack_tgl_c, ack_tgl_s;
    logic [ICW-1:0] ic_cnt;
    logic           round_start, round_done, caps_vld;

    // Decode the write into request set bits. Reserved bits are dropped.
    always_comb begin
        set_bits = '0;
        if (wr_en) begin
            set_bits.dat = wr_data[BIT_DAT];
            set_bits.cmd = wr_data[BIT_CMD];
            set_bits.all = wr_data[BIT_ALL];
        end
    end

    softrst_req_regs u_req (
        .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits), .pend(pend)
    );

    assign round_start = (st == ST_IDLE) && (pend != '0);
    assign round_done  = (st == ST_BUSY) && (ic_cnt == '0) && (ack_tgl_s == req_tgl);

    // Choose which bits to clear at the end of a round. A pending reset-all outside the scope keeps line bits set.
    always_comb begin
        clr_bits = '0;
        if (round_done && !(pend.all && !scope_q.all)) clr_bits = scope_q;
    end

    // Round engine: latch the scope, send the toggle and wait for both sides.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            scope_q <= '0;
            req_tgl <= 1'b0;
            ic_cnt  <= '0;
        end else begin
            case (st)
                ST_IDLE: if (round_start) begin
                    scope_q <= pend;
                    req_tgl <= ~req_tgl;
                    ic_cnt  <= ICW'(IC_HOLD);
                    st      <= ST_BUSY;
                end
                ST_BUSY: begin
                    if (ic_cnt != '0) ic_cnt <= ic_cnt - 1'b1;
                    if (round_done) begin
                        scope_q <= '0;
                        st      <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Issue one clear strobe per group at the start of a round.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clr_dat_grp <= 1'b0;
            clr_cmd_grp <= 1'b0;
        end else begin
            clr_dat_grp <= round_start && (pend.dat || pend.all);
            clr_cmd_grp <= round_start && (pend.cmd || pend.all);
        end
    end

    assign ic_if_rst  = (st == ST_BUSY);
    assign ic_dat_rst = (st == ST_BUSY) && (scope_q.dat || scope_q.all);
    assign ic_cmd_rst = (st == ST_BUSY) && (scope_q.cmd || scope_q.all);
    assign ic_all_rst = (st == ST_BUSY) && scope_q.all;

    softrst_card_side #(.HOLD(CARD_HOLD), .STAGES(SYNC_STAGES)) u_card (
        .cclk(cclk), .crst_n(crst_n), .req_tgl(req_tgl), .scope_in(scope_q),
        .ack_tgl(ack_tgl_c), .rst_dat(cd_dat_rst), .rst_cmd(cd_cmd_rst), .rst_all(cd_all_rst)
    );

    softrst_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl_c), .q(ack_tgl_s)
    );

    softrst_keep #(.CAP_W(CAP_W), .STAGES(SYNC_STAGES)) u_keep (
        .clk(clk), .rst_n(rst_n), .card_det_raw(card_det_raw), .cap_strap(cap_strap),
        .card_present(card_present), .caps(caps), .caps_vld(caps_vld)
    );

    // Assemble the readback word.
    always_comb begin
        rd_data          = '0;
        rd_data[BIT_DAT] = pend.dat;
        rd_data[BIT_CMD] = pend.cmd;
        rd_data[BIT_ALL] = pend.all;
    end
endmodule

// File: rtl/softrst_hub_chk.sv
// Property checker for softrst_hub, attached with bind.
module softrst_hub_chk #(
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             round_done,
    input logic             clr_dat_grp,
    input logic             clr_cmd_grp,
    input logic             ic_if_rst,
    input logic [CAP_W-1:0] caps,
    input logic             caps_vld
);
    p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[31:27] == 5'd0) && (rd_data[23:0] == 24'd0));

    p_set_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[26]) |=> rd_data[26]);

    p_cmd_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[25] && !round_done) |=> rd_data[25]);

    p_dat_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[26] && !round_done) |=> rd_data[26]);

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_dat_grp |=> !clr_dat_grp);

    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd_grp |=> !clr_cmd_grp);

    p_all_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[24]) |-> (rd_data[26:25] == 2'b00));

    p_caps_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(caps_vld) |-> $stable(caps));

    p_strobe_in_round_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_dat_grp || clr_cmd_grp) |-> ic_if_rst);
endmodule

bind softrst_hub softrst_hub_chk #(.CAP_W(CAP_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .round_done(round_done), .clr_dat_grp(clr_dat_grp), .clr_cmd_grp(clr_cmd_grp),
    .ic_if_rst(ic_if_rst), .caps(caps), .caps_vld(caps_vld)
);

// File: tb/softrst_hub_bench.sv
module softrst_hub_bench;
    localparam int CARD_HOLD = 4;
    localparam int IC_HOLD   = 2;
    localparam int CAP_W     = 16;
    localparam logic [31:0] REQ_MASK = 32'h0700_0000;

    logic clk = 1'b0, cclk = 1'b0, rst_n = 1'b0, crst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [CAP_W-1:0] cap_strap = 16'hA5C3;
    logic card_det_raw = 1'b1;
    logic ic_if_rst, ic_dat_rst, ic_cmd_rst, ic_all_rst;
    logic cd_dat_rst, cd_cmd_rst, cd_all_rst;
    logic clr_dat_grp, clr_cmd_grp, card_present;
    logic [CAP_W-1:0] caps;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5  clk  = ~clk;
    always #13 cclk = ~cclk;

    softrst_hub #(.CARD_HOLD(CARD_HOLD), .IC_HOLD(IC_HOLD), .SYNC_STAGES(2), .CAP_W(CAP_W)) u_softrst_hub (
        .clk(clk), .rst_n(rst_n), .cclk(cclk), .crst_n(crst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .cap_strap(cap_strap), .card_det_raw(card_det_raw),
        .ic_if_rst(ic_if_rst), .ic_dat_rst(ic_dat_rst), .ic_cmd_rst(ic_cmd_rst), .ic_all_rst(ic_all_rst),
        .cd_dat_rst(cd_dat_rst), .cd_cmd_rst(cd_cmd_rst), .cd_all_rst(cd_all_rst),
        .clr_dat_grp(clr_dat_grp), .clr_cmd_grp(clr_cmd_grp), .card_present(card_present), .caps(caps)
    );

    // Cumulative monitors, sampled away from the active edges.
    int n_sdat = 0, n_scmd = 0, n_ifr = 0, n_icd = 0, n_icc = 0, n_ica = 0;
    int n_cdd = 0, n_cdc = 0, n_cda = 0, bad_early = 0, bad_tog = 0, run = 0, last_run = 0;
    logic prev_all = 1'b0;

    always @(negedge clk) begin
        if (clr_dat_grp) n_sdat++;
        if (clr_cmd_grp) n_scmd++;
        if (ic_if_rst)   n_ifr++;
        if (ic_dat_rst)  n_icd++;
        if (ic_cmd_rst)  n_icc++;
        if (ic_all_rst)  n_ica++;
        if (prev_all && !rd_data[24] && rd_data[26:25] != 2'b00) bad_tog++;
        prev_all = rd_data[24];
    end

    always @(negedge cclk) begin
        if (cd_dat_rst) n_cdd++;
        if (cd_cmd_rst) n_cdc++;
        if (cd_all_rst) n_cda++;
        if ((cd_dat_rst || cd_cmd_rst || cd_all_rst) && rd_data[26:24] == 3'b000) bad_early++;
        if (cd_dat_rst || cd_cmd_rst || cd_all_rst) run++;
        else if (run != 0) begin last_run = run; run = 0; end
    end

    function automatic logic [31:0] exp_word(input logic [31:0] w);
        return w & REQ_MASK;
    endfunction

    function automatic int exp_dat(input logic [31:0] w);
        return (w[26] || w[24]) ? 1 : 0;
    endfunction

    function automatic int exp_cmd(input logic [31:0] w);
        return (w[25] || w[24]) ? 1 : 0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] w);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic wait_idle(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (rd_data[26:24] == 3'b000 && !ic_if_rst) begin ok = 1'b1; break; end
        end
        repeat (4) @(negedge cclk);
    endtask

    // One round from idle: check readback, self-clear, strobes and the reset outputs in both domains.
    task automatic run_round(input logic [31:0] w);
        int b_sd, b_sc, b_ifr, b_icd, b_icc, b_ica, b_cdd, b_cdc, b_cda, b_be;
        bit ok;
        logic [CAP_W-1:0] caps0;
        logic det0;
        logic [31:0] ew;
        ew = exp_word(w);
        caps0 = caps; det0 = card_present;
        b_sd = n_sdat; b_sc = n_scmd; b_ifr = n_ifr; b_icd = n_icd; b_icc = n_icc;
        b_ica = n_ica; b_cdd = n_cdd; b_cdc = n_cdc; b_cda = n_cda; b_be = bad_early;
        last_run = 0;
        do_write(w);
        chk(rd_data == ew, "R1/R2 readback after write", rd_data, ew);
        if (ew == '0) begin
            repeat (40) @(negedge clk);
            chk(n_ifr == b_ifr, "R1 reserved write starts no round", n_ifr - b_ifr, 0);
            return;
        end
        wait_idle(ok);
        chk(ok, "R2 request bits self-clear", rd_data, 32'h0);
        chk(n_ifr - b_ifr >= IC_HOLD, "R2/R9 interconnect hold cycles", n_ifr - b_ifr, IC_HOLD);
        chk(bad_early == b_be, "R4 request held during card reset", bad_early - b_be, 0);
        chk(last_run >= CARD_HOLD, "R4 card reset length", last_run, CARD_HOLD);
        chk(n_sdat - b_sd == exp_dat(w), "R5 data clear strobe count", n_sdat - b_sd, exp_dat(w));
        chk(n_scmd - b_sc == exp_cmd(w), "R6 cmd clear strobe count", n_scmd - b_sc, exp_cmd(w));
        chk((n_icd != b_icd) == (exp_dat(w) == 1), "R5 ic data reset", n_icd - b_icd, exp_dat(w));
        chk((n_cdd != b_cdd) == (exp_dat(w) == 1), "R5 card data reset", n_cdd - b_cdd, exp_dat(w));
        chk((n_icc != b_icc) == (exp_cmd(w) == 1), "R6 ic cmd reset", n_icc - b_icc, exp_cmd(w));
        chk((n_cdc != b_cdc) == (exp_cmd(w) == 1), "R6 card cmd reset", n_cdc - b_cdc, exp_cmd(w));
        chk((n_ica != b_ica) == w[24], "R7 ic all reset", n_ica - b_ica, w[24]);
        chk((n_cda != b_cda) == w[24], "R7 card all reset", n_cda - b_cda, w[24]);
        chk(caps == caps0, "R8 caps kept", caps, caps0);
        chk(card_present == det0, "R8 card detect kept", card_present, det0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit ok;
        int b_sd, b_sc;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        rst_n = 1'b1; crst_n = 1'b1;
        repeat (3) @(negedge clk);
        cap_strap = 16'h1111;
        repeat (3) @(negedge clk);

        // Reset state
        chk(rd_data == 32'h0, "R1 reset readback", rd_data, 32'h0);
        chk({ic_if_rst, ic_dat_rst, ic_cmd_rst, ic_all_rst} == 4'b0, "R9 reset ic outputs",
            {ic_if_rst, ic_dat_rst, ic_cmd_rst, ic_all_rst}, 0);
        chk({cd_dat_rst, cd_cmd_rst, cd_all_rst, clr_dat_grp, clr_cmd_grp} == 5'b0, "R5 reset card outputs",
            {cd_dat_rst, cd_cmd_rst, cd_all_rst, clr_dat_grp, clr_cmd_grp}, 0);
        chk(caps == 16'hA5C3, "R8 caps captured at reset", caps, 16'hA5C3);
        chk(card_present == 1'b1, "R8 card detect follows input", card_present, 1);

        // Directed single-scope rounds
        run_round(32'hF8FF_FFFF);
        run_round(32'h0400_0000);
        run_round(32'h0200_0000);
        run_round(32'h0100_0000);
        run_round(32'hFFFF_FFFF);

        // R3: zero write ignored, repeated set gives a single round
        b_sd = n_sdat;
        do_write(32'h0400_0000);
        do_write(32'h0000_0000);
        chk(rd_data[26] == 1'b1, "R3 zero write leaves bit pending", rd_data, 32'h0400_0000);
        do_write(32'h0400_0000);
        wait_idle(ok);
        chk(ok, "R3 bit self-clears", rd_data, 0);
        chk(n_sdat - b_sd == 1, "R3 single clear strobe", n_sdat - b_sd, 1);

        // R7: reset-all during a data round covers it, bits clear together
        b_sd = n_sdat; b_sc = n_scmd;
        do_write(32'h0400_0000);
        do_write(32'h0100_0000);
        wait_idle(ok);
        chk(ok, "R7 overlap completes", rd_data, 0);
        chk(bad_tog == 0, "R7 line bit clears with all bit", bad_tog, 0);
        chk(n_scmd - b_sc == 1, "R7 cmd strobe from reset-all", n_scmd - b_sc, 1);
        chk(n_sdat - b_sd == 2, "R7 data strobes across two rounds", n_sdat - b_sd, 2);

        // R8: card detect still follows its input after reset-all
        card_det_raw = 1'b0;
        repeat (4) @(negedge clk);
        chk(card_present == 1'b0, "R8 card detect tracks input", card_present, 0);

        // Constrained random request words from idle
        for (int k = 0; k < 24; k++) begin
            logic [31:0] w;
            w = $urandom;
            if (k % 4 == 0) w = w & ~REQ_MASK;
            run_round(w);
        end
        chk(caps == 16'hA5C3, "R8 caps after all rounds", caps, 16'hA5C3);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule